// File: doc/BRIEF.md
# Pipelined Multiply-Add Unit with Accumulate Mode

This block multiplies two to four pairs of operands in parallel and merges the products into one widened sum. Pairs are combined first (product 0 with 1, product 2 with 3), each such pair either adding or subtracting its second product. When there are three or four products, a second level adds the pair results, plus any unpaired product. Operands, products and the final sum each sit in their own register stage, so a result appears three enabled clock edges after its operands are presented.

A mode input turns the final stage into an accumulator: the combined sum of products is added to the value already in the result register instead of replacing it. A load input, valid in that mode, starts a fresh running total from the current sum of products without needing a clear. All control inputs travel down the pipeline with their operands. A single enable stalls every stage at once, and an asynchronous clear zeroes the whole datapath.

Top module: `muladd_pipe`

## Requirements
- R1: Raising `aclr` forces `result` and every pipeline stage to zero at once, without waiting for a clock edge.
- R2: With `ce` high, operands presented before edge n produce their result just after edge n+2 (three register stages). Before the third enabled edge after a clear, `result` stays zero.
- R3: Lane i takes operands from bits [i*W +: W] of `opa` and `opb`. The combined sum is p0 ± p1 (+ p2 ± p3 when present). `sub_sel[k]` = 1 subtracts product 2k+1 and 0 adds it. An unpaired last product is always added, and the second level always adds.
- R4: With SIGNED = 1, operands and products are treated as two's complement and sign-extended. With SIGNED = 0, they are zero-extended. `result` is 2W + L + GUARD bits wide, where L is 1 for two multipliers and 2 for three or four.
- R5: With `acc_mode` = 1 and `acc_load` = 0, the new result is the previous result plus the combined sum of products.
- R6: With `acc_mode` = 1 and `acc_load` = 1, the new result is the combined sum of products alone, so accumulation restarts.
- R7: With `acc_mode` = 0, `acc_load` has no effect, and the result is the combined sum of products.
- R8: While `ce` is low, no stage changes: `result` holds, and the operands already in flight complete correctly once `ce` returns.
- R9: Sums beyond the result width wrap modulo 2^RW.
- R10: `sub_sel`, `acc_mode` and `acc_load` take effect on the operands presented in the same cycle as themselves, even when they change every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| aclr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for all stages |
| opa | input | NMUL*W (64) | First operand of each lane, lane i at bits [i*W +: W] |
| opb | input | NMUL*W (64) | Second operand of each lane |
| sub_sel | input | NMUL/2 (2) | Per-pair subtract select for the first level |
| acc_mode | input | 1 | 1 = accumulate into result, 0 = plain sum |
| acc_load | input | 1 | In accumulate mode, restart the total from the current sum |
| result | output | RW (38) | Widened sum or running total |

## Verification
Small positive operands are sent back to back with a different `sub_sel` pattern each cycle. This separates correct per-pair subtraction from controls that are misaligned by a stage. Extreme negative operands show whether products are sign-extended or zero-extended. An accumulate run with loads in the middle shows whether the result is fed back or replaced. The same run with a stall inserted shows whether all stages freeze together. A long accumulation of the largest product checks the wrap at the result width. A clear during an accumulation confirms that the running total restarts from zero.

// File: rtl/mad_pkg.sv
package mad_pkg;

  localparam int MAX_OPW   = 32;
  localparam int MAX_LANES = 4;

  typedef logic [MAX_LANES*MAX_OPW-1:0] lane_bus_t;

  // Mask a raw lane to w bits and extend it to 64 bits.
  function automatic logic [63:0] widen(logic [63:0] raw, int unsigned w, bit sgn);
    logic [63:0] m;
    m   = (64'd1 << w) - 64'd1;
    raw = raw & m;
    if (sgn && raw[w-1]) raw = raw | ~m;
    return raw;
  endfunction

  // Sum of lane products with per-pair subtraction, modulo 2^64.
  function automatic logic [63:0] ref_combine(lane_bus_t a, lane_bus_t b, logic [1:0] sub,
                                              int unsigned w, int n, bit sgn);
    logic [63:0] acc, pa, pb, pr;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      pa = widen(64'(a >> (i*w)), w, sgn);
      pb = widen(64'(b >> (i*w)), w, sgn);
      pr = pa * pb;
      if ((i % 2 == 1) && sub[i/2]) acc = acc - pr;
      else                          acc = acc + pr;
    end
    return acc;
  endfunction

endpackage

// File: rtl/mad_stage_reg.sv
module mad_stage_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             aclr,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)    q <= '0;
    else if (ce) q <= d;
  end

endmodule

// File: rtl/mad_mult_bank.sv
module mad_mult_bank #(
  parameter int W      = 16,
  parameter int NMUL   = 4,
  parameter int SIGNED = 1,
  localparam int PW    = 2*W
) (
  input  logic               clk,
  input  logic               aclr,
  input  logic               ce,
  input  logic [NMUL*W-1:0]  a_q,
  input  logic [NMUL*W-1:0]  b_q,
  output logic [NMUL*PW-1:0] prod_q
);

  for (genvar i = 0; i < NMUL; i++) begin : g_lane
    logic [W-1:0]  ra, rb;
    logic [PW-1:0] xa, xb, pd;
    assign ra = a_q[i*W +: W];
    assign rb = b_q[i*W +: W];
    if (SIGNED != 0) begin : g_sext
      assign xa = {{W{ra[W-1]}}, ra};
      assign xb = {{W{rb[W-1]}}, rb};
    end else begin : g_zext
      assign xa = {{W{1'b0}}, ra};
      assign xb = {{W{1'b0}}, rb};
    end
    assign pd = xa * xb;

    mad_stage_reg #(.WIDTH(PW)) u_prod (
      .clk(clk), .aclr(aclr), .ce(ce), .d(pd), .q(prod_q[i*PW +: PW])
    );
  end

endmodule

// File: rtl/mad_combine.sv
module mad_combine #(
  parameter int W       = 16,
  parameter int NMUL    = 4,
  parameter int SIGNED  = 1,
  parameter int GUARD   = 4,
  localparam int PW     = 2*W,
  localparam int LEVELS = (NMUL > 2) ? 2 : 1,
  localparam int RW     = PW + LEVELS + GUARD,
  localparam int NSUB   = NMUL/2,
  localparam int NTERM  = (NMUL+1)/2
) (
  input  logic               clk,
  input  logic               aclr,
  input  logic               ce,
  input  logic [NMUL*PW-1:0] prod_q,
  input  logic [NSUB-1:0]    sub_q,
  input  logic               accm_q,
  input  logic               load_q,
  output logic [RW-1:0]      comb_sum,
  output logic [RW-1:0]      result
);

  logic [RW-1:0] ext  [NMUL];
  logic [RW-1:0] term [NTERM];
  logic [RW-1:0] feedback;

  for (genvar i = 0; i < NMUL; i++) begin : g_ext
    logic [PW-1:0] p;
    assign p = prod_q[i*PW +: PW];
    if (SIGNED != 0) begin : g_s
      assign ext[i] = {{(RW-PW){p[PW-1]}}, p};
    end else begin : g_u
      assign ext[i] = {{(RW-PW){1'b0}}, p};
    end
  end

  // First level: add or subtract within each pair.
  for (genvar k = 0; k < NSUB; k++) begin : g_pair
    assign term[k] = sub_q[k] ? (ext[2*k] - ext[2*k+1]) : (ext[2*k] + ext[2*k+1]);
  end
  if (NMUL % 2 == 1) begin : g_odd
    assign term[NTERM-1] = ext[NMUL-1];
  end

  // Second level: always adds.
  always_comb begin
    comb_sum = '0;
    for (int k = 0; k < NTERM; k++) comb_sum = comb_sum + term[k];
  end

  assign feedback = (accm_q && !load_q) ? result : '0;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)    result <= '0;
    else if (ce) result <= feedback + comb_sum;
  end

endmodule

// File: rtl/muladd_pipe.sv
module muladd_pipe #(
  parameter int W       = 16,
  parameter int NMUL    = 4,
  parameter int SIGNED  = 1,
  parameter int GUARD   = 4,
  localparam int PW     = 2*W,
  localparam int LEVELS = (NMUL > 2) ? 2 : 1,
  localparam int RW     = PW + LEVELS + GUARD,
  localparam int NSUB   = NMUL/2,
  localparam int CW     = NSUB + 2
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              ce,
  input  logic [NMUL*W-1:0] opa,
  input  logic [NMUL*W-1:0] opb,
  input  logic [NSUB-1:0]   sub_sel,
  input  logic              acc_mode,
  input  logic              acc_load,
  output logic [RW-1:0]     result
);

  logic [NMUL*W-1:0]  a_q, b_q;
  logic [CW-1:0]      ctl_d, ctl_q1, ctl_q2;
  logic [NMUL*PW-1:0] prod_q;
  logic [RW-1:0]      comb_sum;
  logic               stage_adv;

  assign stage_adv = ce;
  assign ctl_d     = {sub_sel, acc_mode, acc_load};

  mad_stage_reg #(.WIDTH(NMUL*W)) u_in_a (
    .clk(clk), .aclr(aclr), .ce(stage_adv), .d(opa), .q(a_q)
  );
  mad_stage_reg #(.WIDTH(NMUL*W)) u_in_b (
    .clk(clk), .aclr(aclr), .ce(stage_adv), .d(opb), .q(b_q)
  );
  mad_stage_reg #(.WIDTH(CW)) u_ctl1 (
    .clk(clk), .aclr(aclr), .ce(stage_adv), .d(ctl_d), .q(ctl_q1)
  );
  mad_stage_reg #(.WIDTH(CW)) u_ctl2 (
    .clk(clk), .aclr(aclr), .ce(stage_adv), .d(ctl_q1), .q(ctl_q2)
  );

  mad_mult_bank #(.W(W), .NMUL(NMUL), .SIGNED(SIGNED)) u_mult (
    .clk(clk), .aclr(aclr), .ce(stage_adv), .a_q(a_q), .b_q(b_q), .prod_q(prod_q)
  );

  mad_combine #(.W(W), .NMUL(NMUL), .SIGNED(SIGNED), .GUARD(GUARD)) u_comb (
    .clk(clk), .aclr(aclr), .ce(stage_adv), .prod_q(prod_q),
    .sub_q(ctl_q2[CW-1:2]), .accm_q(ctl_q2[1]), .load_q(ctl_q2[0]),
    .comb_sum(comb_sum), .result(result)
  );

endmodule

// File: rtl/muladd_pipe_chk.sv
module muladd_pipe_chk #(
  parameter int W       = 16,
  parameter int NMUL    = 4,
  parameter int SIGNED  = 1,
  parameter int GUARD   = 4,
  localparam int PW     = 2*W,
  localparam int LEVELS = (NMUL > 2) ? 2 : 1,
  localparam int RW     = PW + LEVELS + GUARD,
  localparam int NSUB   = NMUL/2
) (
  input logic              clk,
  input logic              aclr,
  input logic              ce,
  input logic [NMUL*W-1:0] opa,
  input logic [NMUL*W-1:0] opb,
  input logic [NSUB-1:0]   sub_sel,
  input logic              acc_mode,
  input logic              acc_load,
  input logic [RW-1:0]     result,
  input logic              stage_adv
);
  import mad_pkg::*;

  logic [1:0] seen;
  logic       window;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)              seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end
  assign window = (seen == 2'd3);

  always @(posedge clk) begin
    if (aclr) begin
      assert_clear_zero_R1: assert (result == '0)
        else $error("result not zero under clear");
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (aclr)
    !stage_adv |=> $stable(result));

  assert_plain_sum_R3: assert property (@(posedge clk) disable iff (aclr)
    (window && $past(ce,1) && $past(ce,2) && $past(ce,3) && !$past(acc_mode,3))
    |-> (result == RW'(ref_combine(lane_bus_t'($past(opa,3)), lane_bus_t'($past(opb,3)),
                                    2'($past(sub_sel,3)), W, NMUL, SIGNED != 0))));

  assert_accumulate_R5: assert property (@(posedge clk) disable iff (aclr)
    (window && $past(ce,1) && $past(ce,2) && $past(ce,3) && $past(acc_mode,3) && !$past(acc_load,3))
    |-> (result == RW'($past(result) + RW'(ref_combine(lane_bus_t'($past(opa,3)),
                       lane_bus_t'($past(opb,3)), 2'($past(sub_sel,3)), W, NMUL, SIGNED != 0)))));

  assert_load_R6: assert property (@(posedge clk) disable iff (aclr)
    (window && $past(ce,1) && $past(ce,2) && $past(ce,3) && $past(acc_mode,3) && $past(acc_load,3))
    |-> (result == RW'(ref_combine(lane_bus_t'($past(opa,3)), lane_bus_t'($past(opb,3)),
                                    2'($past(sub_sel,3)), W, NMUL, SIGNED != 0))));

endmodule

bind muladd_pipe muladd_pipe_chk #(.W(W), .NMUL(NMUL), .SIGNED(SIGNED), .GUARD(GUARD)) u_chk (.*);

// File: tb/tb_muladd_pipe.sv
module tb_muladd_pipe;

  localparam int W      = 16;
  localparam int NMUL   = 4;
  localparam int SIGNED = 1;
  localparam int GUARD  = 4;
  localparam int RW     = 2*W + 2 + GUARD;
  localparam int NSUB   = NMUL/2;

  logic              clk = 1'b0;
  logic              aclr = 1'b1;
  logic              ce = 1'b0;
  logic [NMUL*W-1:0] opa = '0, opb = '0;
  logic [NSUB-1:0]   sub_sel = '0;
  logic              acc_mode = 1'b0, acc_load = 1'b0;
  logic [RW-1:0]     result;

  muladd_pipe #(.W(W), .NMUL(NMUL), .SIGNED(SIGNED), .GUARD(GUARD)) dut (
    .clk(clk), .aclr(aclr), .ce(ce), .opa(opa), .opb(opb), .sub_sel(sub_sel),
    .acc_mode(acc_mode), .acc_load(acc_load), .result(result)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0, edges = 0;
  bit done = 0, last_ce = 0, last_clr = 1;
  longint model_last = 0;
  logic [RW-1:0] expq[$];
  string tagq[$];

  task automatic check(bit ok, string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint lane(logic [NMUL*W-1:0] v, int i);
    longint x = 0;
    x[W-1:0] = v[i*W +: W];
    if (SIGNED != 0 && x[W-1]) x = x - (longint'(1) << W);
    return x;
  endfunction

  function automatic longint model_comb(logic [NMUL*W-1:0] a, logic [NMUL*W-1:0] b,
                                        logic [NSUB-1:0] s);
    longint t = 0;
    for (int k = 0; k < NSUB; k++) begin
      longint pe = lane(a, 2*k) * lane(b, 2*k);
      longint po = lane(a, 2*k+1) * lane(b, 2*k+1);
      t += s[k] ? (pe - po) : (pe + po);
    end
    if (NMUL % 2 == 1) t += lane(a, NMUL-1) * lane(b, NMUL-1);
    return t;
  endfunction

  function automatic logic [NMUL*W-1:0] pk(int x0, int x1, int x2, int x3);
    return {W'(x3), W'(x2), W'(x1), W'(x0)};
  endfunction

  task automatic issue(logic [NMUL*W-1:0] a, logic [NMUL*W-1:0] b, logic [NSUB-1:0] s,
                       bit am, bit ld, string tag);
    longint c;
    @(negedge clk);
    opa = a; opb = b; sub_sel = s; acc_mode = am; acc_load = ld; ce = 1'b1;
    c = model_comb(a, b, s);
    if (am && !ld) model_last = model_last + c;
    else           model_last = c;
    expq.push_back(RW'(model_last));
    tagq.push_back(tag);
  endtask

  task automatic flush();
    repeat (3) issue('0, '0, '0, 1'b0, 1'b0, "R2 flush");
    @(negedge clk); ce = 1'b0;
  endtask

  task automatic clear_now(string tag);
    @(negedge clk);
    #1 aclr = 1'b1;
    #1 check(result == '0, tag, result, '0);
    ce = 1'b0;
    @(negedge clk);
    expq.delete(); tagq.delete(); edges = 0; model_last = 0;
    aclr = 1'b0;
  endtask

  task automatic freeze_check(int n);
    logic [RW-1:0] held;
    @(negedge clk);
    ce = 1'b0;
    opa = pk(9, 9, 9, 9); opb = pk(9, 9, 9, 9); acc_mode = 1'b0;
    held = result;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(result == held, "R8 hold while ce low", result, held);
    end
  endtask

  always @(posedge clk) begin
    last_ce  <= ce;
    last_clr <= aclr;
  end

  // Monitor: one expected item per enabled edge, compared from the third edge on.
  always @(negedge clk) begin
    if (last_ce && !last_clr && !aclr) begin
      edges++;
      if (edges < 3) begin
        check(result == '0, "R2 no result before third edge", result, '0);
      end else if (expq.size() == 0) begin
        check(1'b0, "scoreboard underrun", result, '0);
      end else begin
        logic [RW-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(result == e, t, result, e);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(result == '0, "R1 reset state", result, '0);
    aclr = 1'b0;

    // R2 R3 R10: back to back, sub pattern changes each cycle
    issue(pk(1, 2, 3, 4), pk(5, 6, 7, 8), 2'b00, 0, 0, "R3 all add");
    issue(pk(1, 2, 3, 4), pk(5, 6, 7, 8), 2'b01, 0, 0, "R3 R10 sub pair0");
    issue(pk(1, 2, 3, 4), pk(5, 6, 7, 8), 2'b10, 0, 0, "R3 R10 sub pair1");
    issue(pk(1, 2, 3, 4), pk(5, 6, 7, 8), 2'b11, 0, 0, "R3 R10 sub both");
    // R4: signed extremes and mixed signs
    issue(pk(-3, 7, -100, 250), pk(11, -13, -9, 4), 2'b00, 0, 0, "R4 mixed signs");
    issue(pk(-32768, -32768, -32768, -32768), pk(-32768, -32768, -32768, -32768), 2'b00, 0, 0, "R4 max positive products");
    issue(pk(-32768, 32767, -32768, 32767), pk(32767, -32768, 32767, -32768), 2'b00, 0, 0, "R4 most negative products");
    issue(pk(-32768, -32768, 5, -32768), pk(-32768, 32767, 5, 32767), 2'b11, 0, 0, "R4 subtract negatives");
    // R7: load ignored outside accumulate mode
    issue(pk(2, 3, 4, 5), pk(2, 3, 4, 5), 2'b00, 0, 1, "R7 load without acc mode");
    issue(pk(1, 1, 1, 1), pk(1, 1, 1, 1), 2'b00, 0, 1, "R7 load without acc mode 2");
    // R5 R6: accumulate with restarts
    issue(pk(10, 0, 0, 0), pk(10, 0, 0, 0), 2'b00, 1, 1, "R6 load start");
    for (int i = 0; i < 5; i++) issue(pk(i, 2, -1, 3), pk(3, i, 4, -2), 2'(i), 1, 0, "R5 accumulate");
    issue(pk(7, 0, 0, 0), pk(7, 0, 0, 0), 2'b00, 1, 1, "R6 reload mid run");
    issue(pk(1, 0, 0, 0), pk(1, 0, 0, 0), 2'b00, 1, 0, "R5 add after reload");
    // R8: stall in the middle of an accumulation
    issue(pk(3, 3, 3, 3), pk(3, 3, 3, 3), 2'b00, 1, 0, "R8 acc before stall");
    issue(pk(5, 5, 5, 5), pk(2, 2, 2, 2), 2'b01, 1, 0, "R8 acc before stall 2");
    freeze_check(4);
    issue(pk(1, 2, 1, 2), pk(1, 2, 1, 2), 2'b00, 1, 0, "R8 acc after stall");
    issue(pk(4, 4, 4, 4), pk(4, 4, 4, 4), 2'b10, 0, 0, "R8 plain after stall");
    flush();

    // R9: accumulate 2^32 per cycle past the 38-bit width
    issue(pk(-32768, -32768, -32768, -32768), pk(-32768, -32768, -32768, -32768), 2'b00, 1, 1, "R9 wrap start");
    for (int i = 0; i < 69; i++)
      issue(pk(-32768, -32768, -32768, -32768), pk(-32768, -32768, -32768, -32768), 2'b00, 1, 0, "R9 wrap");
    flush();

    // R1: clear during accumulation, then accumulate from zero without load
    issue(pk(100, 100, 100, 100), pk(100, 100, 100, 100), 2'b00, 1, 1, "R6 before clear");
    issue(pk(100, 100, 100, 100), pk(100, 100, 100, 100), 2'b00, 1, 0, "R5 before clear");
    clear_now("R1 async clear mid run");
    issue(pk(6, 0, 0, 0), pk(6, 0, 0, 0), 2'b00, 1, 0, "R1 R5 accumulate from zero");
    issue(pk(6, 0, 0, 0), pk(6, 0, 0, 0), 2'b00, 1, 0, "R5 accumulate from zero 2");
    flush();

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule